// File: doc/BRIEF.md
# Handshaked Bus Read Controller

This block pairs a read master with a device-side responder on a small synchronous parallel bus. The two sides never share a fixed latency. Each transfer is framed by a four-phase handshake. The master raises an enquiry line and holds the address and a read/write-bar line. The responder raises an acknowledge with the data, then lowers it when it is finished. Only after that does the master lower the enquiry. Each side runs its own state sequence. The master goes through address, wait, get-data and done. The responder goes through address, wait, send-data and release-ack.

A client hands in a read address when the controller shows it is ready. It then gets back either one response pulse with the data or one error pulse. The responder answers only for addresses inside a base/size window set by parameters. Before it acknowledges, it holds the bus for a programmable number of wait cycles. The master gives up after a programmable number of cycles without an acknowledge. When it gives up, it drops the enquiry and reports an error. The bus lines are brought out as outputs so that the handshake can be observed.

Top module: `rdbus_read_ctrl`

## Requirements
- R1: `req_ready` is high only when the master is idle and both `bus_enq` and `bus_ack` are low. A request accepted at a clock edge shows `bus_enq` high and `bus_addr` equal to the request address after that edge, and `req_ready` goes low.
- R2: `bus_rw_n` is high (read) during every cycle in which `bus_enq` is high.
- R3: The responder acknowledges only addresses A with WIN_BASE <= A < WIN_BASE+WIN_SIZE (default 0x1000 to 0x10FF). For any other address `bus_ack` stays low and the read ends in a timeout.
- R4: With wait setting W, `bus_ack` rises W+1 clock edges after the edge that accepted the request. W=0 gives no wait cycles.
- R5: `bus_ack` is high for exactly one cycle. In that cycle `bus_data` carries the bitwise complement of the address, zero-extended to the data width.
- R6: A successful read gives a one-cycle `rsp_valid` pulse W+3 edges after the accepting edge. `rsp_data` equals the value from R5, and `rsp_err` stays low.
- R7: On a successful read, `bus_enq` falls only after `bus_ack` has fallen.
- R8: With timeout setting T, if no acknowledge is seen during T cycles in the wait state, `rsp_err` pulses for one cycle T+1 edges after acceptance. In that case `bus_enq` is low and no `rsp_valid` occurs. A setting of 0 acts as 1.
- R9: A read succeeds exactly when T >= W+1. With T = W, the read times out.
- R10: An acknowledge that arrives after the master has aborted produces no response. `req_ready` stays low while that stray `bus_ack` is high.
- R11: If `bus_enq` falls while the responder is still counting wait cycles, the responder abandons the transfer and never raises `bus_ack` for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | 8 | Responder wait cycles before acknowledge |
| cfg_timeout | input | 8 | Master wait-state cycles before abort |
| req_valid | input | 1 | Read request present |
| req_addr | input | 16 | Read request address |
| req_ready | output | 1 | Request accepted at this edge if valid |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_data | output | 32 | Data of the completed read |
| rsp_err | output | 1 | One-cycle pulse: read aborted on timeout |
| bus_enq | output | 1 | Bus enquiry line driven by the master |
| bus_rw_n | output | 1 | Read (high) / write-bar line |
| bus_addr | output | 16 | Bus address driven by the master |
| bus_ack | output | 1 | Bus acknowledge driven by the responder |
| bus_data | output | 32 | Bus data driven by the responder |

## Verification
Every result is timed from the clock edge that accepts the request, called edge 0. The enquiry and address are due after edge 0. The acknowledge is due after edge W+1, the response pulse after edge W+3, and the error pulse after edge T+1. The bench drives and samples at falling edges. It counts falling edges from edge 0 and records the index at which each output is first seen. Each index is then compared with the value worked out from W and T, so a one-cycle slip in any of these results is reported as a failure.

// File: rtl/rdbus_pkg.sv
package rdbus_pkg;

    localparam int unsigned ADDR_W_DEF = 16;
    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned CNT_W_DEF  = 8;

    // Master sequence: idle, address, wait, get-data, done
    typedef enum logic [2:0] {
        M_IDLE = 3'd0,
        M_ADDR = 3'd1,
        M_WAIT = 3'd2,
        M_GETD = 3'd3,
        M_DONE = 3'd4
    } mst_state_e;

    // Responder sequence: address (listening), wait, send-data, release-ack
    typedef enum logic [1:0] {
        D_ADDR = 2'd0,
        D_WAIT = 2'd1,
        D_SEND = 2'd2,
        D_REL  = 2'd3
    } dev_state_e;

    // True when x is a nonzero power of two
    function automatic bit is_pow2(input longint unsigned x);
        return (x != 0) && ((x & (x - 1)) == 0);
    endfunction

endpackage

// File: rtl/rdbus_master.sv
module rdbus_master
    import rdbus_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_timeout,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              bus_enq,
    output logic              bus_rw_n,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err
);

    mst_state_e        st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  tcnt_q;
    logic              err_q;
    logic              accept;
    logic              tmo_hit;
    logic              abort;

    assign req_ready = (st_q == M_IDLE) && !bus_enq && !bus_ack;
    assign accept    = req_valid && req_ready;
    assign tmo_hit   = ({1'b0, tcnt_q} + 1'b1) >= {1'b0, cfg_timeout};
    assign abort     = (st_q == M_WAIT) && !bus_ack && tmo_hit;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            M_IDLE: if (accept) st_d = M_ADDR;
            M_ADDR: st_d = M_WAIT;
            M_WAIT: begin
                if (bus_ack)      st_d = M_GETD;
                else if (tmo_hit) st_d = M_IDLE;
            end
            M_GETD: if (!bus_ack) st_d = M_DONE;
            M_DONE: st_d = M_IDLE;
            default: st_d = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= M_IDLE;
            addr_q <= '0;
            data_q <= '0;
            tcnt_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= abort;
            if (accept) addr_q <= req_addr;
            if (st_q == M_ADDR)      tcnt_q <= '0;
            else if (st_q == M_WAIT) tcnt_q <= tcnt_q + 1'b1;
            if ((st_q == M_WAIT) && bus_ack) data_q <= bus_data;
        end
    end

    assign bus_enq   = (st_q == M_ADDR) || (st_q == M_WAIT) || (st_q == M_GETD);
    assign bus_rw_n  = 1'b1;
    assign bus_addr  = addr_q;
    assign rsp_valid = (st_q == M_DONE);
    assign rsp_data  = data_q;
    assign rsp_err   = err_q;

    // R1: enquiry only starts on a quiet bus
    a_r1_enq_on_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_enq) |-> !$past(bus_ack));

    // R7: enquiry released only once acknowledge is low
    a_r7_enq_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_enq) |-> !$past(bus_ack));

    // R8: error is a single-cycle pulse
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_err |=> !rsp_err);

    // R8: after an abort the enquiry is already released
    a_r8_err_enq_low: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> !bus_enq);

    // R6: response pulse is single-cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/rdbus_responder.sv
module rdbus_responder
    import rdbus_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter int unsigned CNT_W    = CNT_W_DEF,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1000,
    parameter int unsigned WIN_SIZE = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic              bus_enq,
    input  logic              bus_rw_n,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_data
);

    localparam bit USE_MASK = is_pow2(longint'(WIN_SIZE)) &&
                              ((longint'(WIN_BASE) % longint'(WIN_SIZE)) == 0);
    localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_SIZE);

    dev_state_e        st_q, st_d;
    logic [CNT_W-1:0]  wcnt_q;
    logic [DATA_W-1:0] dat_q;
    logic              hit;
    logic              go_send;

    generate
        if (USE_MASK) begin : g_mask
            localparam logic [ADDR_W-1:0] HI_MASK = ~(ADDR_W'(WIN_SIZE - 1));
            assign hit = (bus_addr & HI_MASK) == WIN_BASE;
        end else begin : g_range
            assign hit = ({1'b0, bus_addr} >= {1'b0, WIN_BASE}) &&
                         ({1'b0, bus_addr} < WIN_END);
        end
    endgenerate

    function automatic logic [DATA_W-1:0] reply_word(input logic [ADDR_W-1:0] a);
        return ~(DATA_W'(a));
    endfunction

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            D_ADDR: if (bus_enq && bus_rw_n && hit)
                        st_d = (cfg_wait == '0) ? D_SEND : D_WAIT;
            D_WAIT: begin
                if (!bus_enq)             st_d = D_ADDR;
                else if (wcnt_q == 1'b1)  st_d = D_SEND;
            end
            D_SEND: st_d = D_REL;
            D_REL:  if (!bus_enq) st_d = D_ADDR;
            default: st_d = D_ADDR;
        endcase
    end

    assign go_send = (st_d == D_SEND) && (st_q != D_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= D_ADDR;
            wcnt_q <= '0;
            dat_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == D_ADDR)      wcnt_q <= cfg_wait;
            else if (st_q == D_WAIT) wcnt_q <= wcnt_q - 1'b1;
            if (go_send) dat_q <= reply_word(bus_addr);
        end
    end

    assign bus_ack  = (st_q == D_SEND);
    assign bus_data = bus_ack ? dat_q : '0;

    // R3: acknowledge only for addresses inside the window
    a_r3_ack_in_window: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> hit);

    // R4: acknowledge only follows a live enquiry
    a_r4_ack_needs_enq: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(bus_enq));

    // R5: acknowledge lasts one cycle
    a_r5_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    // R2: responder only ever serves reads
    a_r2_read_only: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(bus_rw_n));

endmodule

// File: rtl/rdbus_read_ctrl.sv
module rdbus_read_ctrl
    import rdbus_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter int unsigned CNT_W    = CNT_W_DEF,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1000,
    parameter int unsigned WIN_SIZE = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_timeout,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              bus_enq,
    output logic              bus_rw_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_data
);

    rdbus_master #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_mst (
        .clk         (clk),
        .rst         (rst),
        .cfg_timeout (cfg_timeout),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_ready   (req_ready),
        .bus_enq     (bus_enq),
        .bus_rw_n    (bus_rw_n),
        .bus_addr    (bus_addr),
        .bus_ack     (bus_ack),
        .bus_data    (bus_data),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_err     (rsp_err)
    );

    rdbus_responder #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_dev (
        .clk      (clk),
        .rst      (rst),
        .cfg_wait (cfg_wait),
        .bus_enq  (bus_enq),
        .bus_rw_n (bus_rw_n),
        .bus_addr (bus_addr),
        .bus_ack  (bus_ack),
        .bus_data (bus_data)
    );

endmodule

// File: tb/rdbus_read_ctrl_tb.sv
module rdbus_read_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN_LEN    = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cfg_wait;
    logic [7:0]  cfg_timeout;
    logic        req_valid;
    logic [15:0] req_addr;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;
    logic        bus_enq;
    logic        bus_rw_n;
    logic [15:0] bus_addr;
    logic        bus_ack;
    logic [31:0] bus_data;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdbus_read_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_wait    (cfg_wait),
        .cfg_timeout (cfg_timeout),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_err     (rsp_err),
        .bus_enq     (bus_enq),
        .bus_rw_n    (bus_rw_n),
        .bus_addr    (bus_addr),
        .bus_ack     (bus_ack),
        .bus_data    (bus_data)
    );

    // observations of one read, indexed by falling edges after the accept edge
    int          o_ack_at, o_valid_at, o_err_at;
    int          o_ack_cnt, o_valid_cnt, o_err_cnt;
    logic [31:0] o_bus_data, o_rsp_data;
    logic        o_ready_at_ack;
    bit          o_rw_ok, o_order_ok, o_enq0, o_ready0;
    logic [15:0] o_addr0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (req_ready) return;
        end
        chk(1'b0, "R1", "ready never seen", 0, 1);
    endtask

    task automatic run_read(input logic [15:0] a, input logic [7:0] w, input logic [7:0] t);
        logic prev_enq, prev_ack;
        cfg_wait    = w;
        cfg_timeout = t;
        wait_ready();
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        o_enq0 = bus_enq; o_addr0 = bus_addr; o_ready0 = req_ready;
        o_ack_at = -1; o_valid_at = -1; o_err_at = -1;
        o_ack_cnt = 0; o_valid_cnt = 0; o_err_cnt = 0;
        o_rw_ok = 1'b1; o_order_ok = 1'b1; o_ready_at_ack = 1'b0;
        o_bus_data = '0; o_rsp_data = '0;
        prev_enq = 1'b1; prev_ack = 1'b0;
        for (int j = 0; j < WIN_LEN; j++) begin
            if (j > 0) @(negedge clk);
            if (bus_enq && !bus_rw_n) o_rw_ok = 1'b0;
            if (prev_enq && !bus_enq && (bus_ack || prev_ack)) o_order_ok = 1'b0;
            if (bus_ack) begin
                o_ack_cnt++;
                if (o_ack_at < 0) begin
                    o_ack_at = j; o_bus_data = bus_data; o_ready_at_ack = req_ready;
                end
            end
            if (rsp_valid) begin
                o_valid_cnt++;
                if (o_valid_at < 0) begin o_valid_at = j; o_rsp_data = rsp_data; end
            end
            if (rsp_err) begin
                o_err_cnt++;
                if (o_err_at < 0) o_err_at = j;
            end
            prev_enq = bus_enq; prev_ack = bus_ack;
        end
    endtask

    function automatic logic [31:0] reply_of(input logic [15:0] a);
        return ~{16'h0000, a};
    endfunction

    task automatic check_ok(input logic [15:0] a, input int w, input string tag);
        chk(o_enq0 == 1'b1, "R1", {tag, " enq after accept"}, o_enq0, 1);
        chk(o_addr0 == a, "R1", {tag, " bus addr"}, o_addr0, a);
        chk(o_ready0 == 1'b0, "R1", {tag, " ready low when busy"}, o_ready0, 0);
        chk(o_rw_ok, "R2", {tag, " rw_n high during enq"}, o_rw_ok, 1);
        chk(o_ack_at == w + 1, "R4", {tag, " ack timing"}, o_ack_at, w + 1);
        chk(o_ack_cnt == 1, "R5", {tag, " ack width"}, o_ack_cnt, 1);
        chk(o_bus_data == reply_of(a), "R5", {tag, " bus data"}, o_bus_data, reply_of(a));
        chk(o_valid_at == w + 3, "R6", {tag, " rsp timing"}, o_valid_at, w + 3);
        chk(o_valid_cnt == 1, "R6", {tag, " rsp pulse count"}, o_valid_cnt, 1);
        chk(o_rsp_data == reply_of(a), "R6", {tag, " rsp data"}, o_rsp_data, reply_of(a));
        chk(o_err_cnt == 0, "R6", {tag, " no error"}, o_err_cnt, 0);
        chk(o_order_ok, "R7", {tag, " enq falls after ack"}, o_order_ok, 1);
    endtask

    task automatic check_tmo(input int t, input string req, input string tag);
        int eff;
        eff = (t < 1) ? 1 : t;
        chk(o_err_at == eff + 1, req, {tag, " err timing"}, o_err_at, eff + 1);
        chk(o_err_cnt == 1, "R8", {tag, " err pulse count"}, o_err_cnt, 1);
        chk(o_valid_cnt == 0, "R8", {tag, " no response"}, o_valid_cnt, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; cfg_wait = '0; cfg_timeout = 8'd8;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_enq && !bus_ack && !rsp_valid && !rsp_err, "R1", "reset quiet bus",
            {bus_enq, bus_ack, rsp_valid, rsp_err}, 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    endtask

    task automatic t_zero_wait();
        run_read(16'h1000, 8'd0, 8'd4);
        check_ok(16'h1000, 0, "R4 zero wait base");
    endtask

    task automatic t_waits_top();
        run_read(16'h10FF, 8'd3, 8'd8);
        check_ok(16'h10FF, 3, "R3 top of window");
    endtask

    task automatic t_boundary_ok();
        run_read(16'h1055, 8'd3, 8'd4);
        check_ok(16'h1055, 3, "R9 T=W+1");
    endtask

    task automatic t_boundary_tmo_stale();
        run_read(16'h10A0, 8'd3, 8'd3);
        check_tmo(3, "R9", "T=W");
        chk(o_ack_at == 4, "R10", "stale ack seen", o_ack_at, 4);
        chk(o_ready_at_ack == 1'b0, "R10", "ready low on stale ack", o_ready_at_ack, 0);
    endtask

    task automatic t_out_above();
        run_read(16'h1100, 8'd0, 8'd5);
        check_tmo(5, "R8", "R3 above window");
        chk(o_ack_cnt == 0, "R3", "no ack above window", o_ack_cnt, 0);
    endtask

    task automatic t_out_below_zero_tmo();
        run_read(16'h0FFF, 8'd0, 8'd0);
        check_tmo(0, "R8", "R3 below window T=0");
        chk(o_ack_cnt == 0, "R3", "no ack below window", o_ack_cnt, 0);
    endtask

    task automatic t_abandon();
        run_read(16'h1010, 8'd5, 8'd2);
        check_tmo(2, "R8", "R11 abandon");
        chk(o_ack_cnt == 0, "R11", "responder abandons wait", o_ack_cnt, 0);
    endtask

    task automatic t_after_abort();
        run_read(16'h1020, 8'd1, 8'd6);
        check_ok(16'h1020, 1, "R10 read after aborts");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_zero_wait();
        t_waits_top();
        t_boundary_ok();
        t_boundary_tmo_stale();
        t_out_above();
        t_out_below_zero_tmo();
        t_abandon();
        t_after_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule